// File: doc/BRIEF.md
# Two-level interrupt status controller

This block holds the interrupt logic of a random-number peripheral. A core layer keeps three sticky event flags: generation complete, noise-source fault and continuous-test fault. Each has an enable bit and a clear bit in one control register. The enabled flags are ORed into a combined core interrupt. That combined bit, together with a sticky bus-error bit, forms a two-bit top-level status. A mask, a mask-enable register and a mask-disable register sit over the top-level status and drive a single level-sensitive interrupt line.

Register writes arrive as a one-cycle strobe with a byte address and 32-bit data. Reads are a combinational mux on a separate read address. The generator supplies event pulses and a qualifier that says the noise source is running. Faults are taken only while that qualifier is high. A parameter selects the older hardware variant, in which a continuous-test fault is also gated by a test-unit enable input.

Top module: `rng_irq_ctrl`

## Requirements
- R1: The control register at offset 0x00 holds the enables for complete, noise fault and test fault in bits 0, 1 and 2, and these read back. Its clear bits 3, 4 and 5 (same event order) always read as zero.
- R2: Writing 1 to a clear bit zeroes the matching flag in the core status register at offset 0x04 by the next clock edge. That register shows complete in bit 0, noise fault in bit 1 and test fault in bit 3.
- R3: Bit 0 of the top status register at offset 0x08 equals the OR over the three events of flag AND enable. It follows any change of a flag or an enable on the same edge. Writing 1 to it has no lasting effect.
- R4: Bit 1 of the top status register is set by an `err_evt` pulse and holds until software writes 1 to it.
- R5: The mask at offset 0x0C resets to 0x3 and ignores direct writes. A write to offset 0x10 clears the written mask bits, and a write to offset 0x14 sets them. Both of these registers read as zero.
- R6: `irq` is a register. It is high exactly when (top status AND NOT mask) is nonzero, and it changes on the same edge as the status and mask it reflects.
- R7: A noise-fault or test-fault pulse is ignored while `src_ok` is low. A complete pulse is always accepted.
- R8: With LEGACY_HW=1, a test-fault pulse is accepted only while `cert_unit_en` is high. With LEGACY_HW=0, `cert_unit_en` has no effect.
- R9: When an event pulse and a clear write for the same flag or status bit land in the same cycle, the bit ends up set.
- R10: A `soft_rst` pulse clears all three core flags and the combined core bit by the next edge, taking priority over events in the same cycle. It leaves the enables, the mask and the bus-error bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Read data (combinational) |
| evt_done | input | 1 | Generation-complete pulse |
| evt_dtf | input | 1 | Noise-source fault pulse |
| evt_certf | input | 1 | Continuous-test fault pulse |
| err_evt | input | 1 | Bus-error pulse |
| src_ok | input | 1 | Noise source running (reset released, source and oscillator enabled) |
| cert_unit_en | input | 1 | Test-unit enable, used only by the older variant |
| soft_rst | input | 1 | Soft reset of the core flags |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds two copies side by side with the same stimulus. One uses LEGACY_HW=0 and the other LEGACY_HW=1, and both use the default 8-bit address and 32-bit data. Because the two copies differ only in the test-fault gate, one test-fault pulse with `cert_unit_en` low shows both arms of R8 at once: the flag is taken in the newer copy and dropped in the older one. Every other check must give the same result in both copies.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;
    localparam int EVT_N   = 3;
    localparam int EV_DONE = 0;
    localparam int EV_DTF  = 1;
    localparam int EV_CERT = 2;
    localparam int TOP_N   = 2;

    typedef logic [EVT_N-1:0] evt_vec_t;
    typedef logic [TOP_N-1:0] top_vec_t;

    typedef struct packed {
        evt_vec_t flags;
        evt_vec_t en;
    } core_st_t;

    typedef struct packed {
        top_vec_t stat;
        top_vec_t mask;
        logic     irq;
    } top_st_t;
endpackage

// File: rtl/core_evt_flags.sv
module core_evt_flags
    import rng_irq_pkg::*;
#(
    parameter bit LEGACY_HW = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_we,
    input  evt_vec_t en_wdata,
    input  evt_vec_t clr,
    input  evt_vec_t evt,
    input  logic     src_ok,
    input  logic     cert_unit_en,
    input  logic     soft_rst,
    output evt_vec_t flags,
    output evt_vec_t enables,
    output logic     core_pend_d
);
    core_st_t st_d, st_q;
    evt_vec_t accept;
    logic     cert_gate;

    generate
        if (LEGACY_HW) begin : g_legacy
            assign cert_gate = cert_unit_en;
        end else begin : g_modern
            assign cert_gate = 1'b1;
        end
    endgenerate

    always_comb begin
        accept          = '0;
        accept[EV_DONE] = evt[EV_DONE];
        accept[EV_DTF]  = evt[EV_DTF] & src_ok;
        accept[EV_CERT] = evt[EV_CERT] & src_ok & cert_gate;

        st_d = st_q;
        if (en_we) begin
            st_d.en = en_wdata;
        end
        st_d.flags = (st_q.flags & ~clr) | accept;
        if (soft_rst) begin
            st_d.flags = '0;
        end
        core_pend_d = |(st_d.flags & st_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags   = st_q.flags;
    assign enables = st_q.en;
endmodule

// File: rtl/top_irq_reg.sv
module top_irq_reg
    import rng_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     core_pend_d,
    input  logic     err_evt,
    input  logic     w1c_we,
    input  logic     mask_en_we,
    input  logic     mask_dis_we,
    input  top_vec_t wdata,
    output top_vec_t stat,
    output top_vec_t mask,
    output logic     irq
);
    top_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.stat[0] = core_pend_d;
        st_d.stat[1] = (st_q.stat[1] & ~(w1c_we & wdata[1])) | err_evt;
        if (mask_en_we) begin
            st_d.mask = st_q.mask & ~wdata;
        end
        if (mask_dis_we) begin
            st_d.mask = st_q.mask | wdata;
        end
        st_d.irq = |(st_d.stat & ~st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= '1;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
    assign mask = st_q.mask;
    assign irq  = st_q.irq;
endmodule

// File: rtl/rng_irq_ctrl.sv
module rng_irq_ctrl
    import rng_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter bit LEGACY_HW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              evt_done,
    input  logic              evt_dtf,
    input  logic              evt_certf,
    input  logic              err_evt,
    input  logic              src_ok,
    input  logic              cert_unit_en,
    input  logic              soft_rst,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_CSTAT = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFS_TSTAT = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] OFS_MEN   = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] OFS_MDIS  = ADDR_W'(8'h14);
    localparam int CLR_LSB = EVT_N;
    localparam int CSTAT_CERT_BIT = 3;

    logic     ctrl_we, w1c_we, mask_en_we, mask_dis_we;
    evt_vec_t clr_bits, evt_vec, flags, enables;
    logic     core_pend_d;
    top_vec_t top_stat, top_mask;
    logic     unused_wdata;

    assign ctrl_we     = wr_en && (wr_addr == OFS_CTRL);
    assign w1c_we      = wr_en && (wr_addr == OFS_TSTAT);
    assign mask_en_we  = wr_en && (wr_addr == OFS_MEN);
    assign mask_dis_we = wr_en && (wr_addr == OFS_MDIS);
    assign clr_bits    = ctrl_we ? wr_data[CLR_LSB +: EVT_N] : '0;
    assign unused_wdata = ^wr_data[DATA_W-1:2*EVT_N];

    always_comb begin
        evt_vec          = '0;
        evt_vec[EV_DONE] = evt_done;
        evt_vec[EV_DTF]  = evt_dtf;
        evt_vec[EV_CERT] = evt_certf;
    end

    core_evt_flags #(.LEGACY_HW(LEGACY_HW)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_we        (ctrl_we),
        .en_wdata     (wr_data[EVT_N-1:0]),
        .clr          (clr_bits),
        .evt          (evt_vec),
        .src_ok       (src_ok),
        .cert_unit_en (cert_unit_en),
        .soft_rst     (soft_rst),
        .flags        (flags),
        .enables      (enables),
        .core_pend_d  (core_pend_d)
    );

    top_irq_reg u_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_pend_d (core_pend_d),
        .err_evt     (err_evt),
        .w1c_we      (w1c_we),
        .mask_en_we  (mask_en_we),
        .mask_dis_we (mask_dis_we),
        .wdata       (wr_data[TOP_N-1:0]),
        .stat        (top_stat),
        .mask        (top_mask),
        .irq         (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_CTRL:  rd_data[EVT_N-1:0] = enables;
            OFS_CSTAT: begin
                rd_data[0]              = flags[EV_DONE];
                rd_data[1]              = flags[EV_DTF];
                rd_data[CSTAT_CERT_BIT] = flags[EV_CERT];
            end
            OFS_TSTAT: rd_data[TOP_N-1:0] = top_stat;
            OFS_MASK:  rd_data[TOP_N-1:0] = top_mask;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rng_irq_ctrl_chk.sv
module rng_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] flags,
    input logic [2:0] enables,
    input logic [1:0] top_stat,
    input logic [1:0] top_mask,
    input logic       irq,
    input logic       mask_en_we,
    input logic [1:0] wr_low,
    input logic       src_ok,
    input logic       evt_done,
    input logic       err_evt,
    input logic       soft_rst
);
    AST_CORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        top_stat[0] == |(flags & enables)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> top_stat[1]); // R4
    AST_MASK_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mask_en_we |=> ((top_mask & $past(wr_low)) == 2'b00)); // R5
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(top_stat & ~top_mask)); // R6
    AST_DTF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ok && !flags[1]) |=> !flags[1]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && !soft_rst) |=> flags[0]); // R9
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flags == 3'b000 && !top_stat[0])); // R10
endmodule

bind rng_irq_ctrl rng_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags      (flags),
    .enables    (enables),
    .top_stat   (top_stat),
    .top_mask   (top_mask),
    .irq        (irq),
    .mask_en_we (mask_en_we),
    .wr_low     (wr_data[1:0]),
    .src_ok     (src_ok),
    .evt_done   (evt_done),
    .err_evt    (err_evt),
    .soft_rst   (soft_rst)
);

// File: tb/sim_rng_irq_ctrl.sv
module sim_rng_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data0, rd_data1;
    logic        evt_done = 1'b0, evt_dtf = 1'b0, evt_certf = 1'b0, err_evt = 1'b0;
    logic        src_ok = 1'b1, cert_unit_en = 1'b0, soft_rst = 1'b0;
    logic        irq0, irq1;
    int          n_chk = 0;
    int          n_err = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    rng_irq_ctrl #(.LEGACY_HW(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data0), .evt_done(evt_done), .evt_dtf(evt_dtf),
        .evt_certf(evt_certf), .err_evt(err_evt), .src_ok(src_ok),
        .cert_unit_en(cert_unit_en), .soft_rst(soft_rst), .irq(irq0));

    rng_irq_ctrl #(.LEGACY_HW(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data1), .evt_done(evt_done), .evt_dtf(evt_dtf),
        .evt_certf(evt_certf), .err_evt(err_evt), .src_ok(src_ok),
        .cert_unit_en(cert_unit_en), .soft_rst(soft_rst), .irq(irq1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v0, output logic [31:0] v1);
        rd_addr = a;
        #0.5;
        v0 = rd_data0;
        v1 = rd_data1;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: evt_done = 1'b1;
            1: evt_dtf = 1'b1;
            2: evt_certf = 1'b1;
            default: err_evt = 1'b1;
        endcase
        @(negedge clk);
        evt_done = 1'b0; evt_dtf = 1'b0; evt_certf = 1'b0; err_evt = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] a, b;
        rd(8'h00, a, b); check("R1 ctrl reset", a, 32'h0);
        rd(8'h04, a, b); check("R2 core status reset", a, 32'h0);
        rd(8'h08, a, b); check("R3 top status reset", a, 32'h0);
        rd(8'h0C, a, b); check("R5 mask reset", a, 32'h3);
        check("R6 irq reset", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_done_path();
        logic [31:0] a, b;
        pulse(0);
        rd(8'h04, a, b); check("R2 done flag set", a, 32'h1);
        rd(8'h08, a, b); check("R3 core bit off while disabled", a, 32'h0);
        wr(8'h00, 32'h1);
        rd(8'h08, a, b); check("R3 core bit follows enable", a, 32'h1);
        check("R6 irq masked", {31'b0, irq0}, 32'h0);
        rd(8'h00, a, b); check("R1 enable readback", a, 32'h1);
        wr(8'h0C, 32'h0);
        rd(8'h0C, a, b); check("R5 mask ignores direct write", a, 32'h3);
        wr(8'h10, 32'h1);
        rd(8'h0C, a, b); check("R5 mask enable clears bit", a, 32'h2);
        rd(8'h10, a, b); check("R5 enable reg reads zero", a, 32'h0);
        check("R6 irq unmasked", {31'b0, irq0}, 32'h1);
        wr(8'h08, 32'h1);
        rd(8'h08, a, b); check("R3 w1c on core bit no effect", a, 32'h1);
        wr(8'h00, 32'h9);
        rd(8'h04, a, b); check("R2 clear bit zeroes flag", a, 32'h0);
        rd(8'h08, a, b); check("R3 core bit drops", a, 32'h0);
        check("R6 irq drops", {31'b0, irq0}, 32'h0);
        rd(8'h00, a, b); check("R1 clear bits read zero", a, 32'h1);
    endtask

    task automatic t_err_bit();
        logic [31:0] a, b;
        pulse(3);
        rd(8'h08, a, b); check("R4 error bit set", a, 32'h2);
        check("R6 irq masked error", {31'b0, irq0}, 32'h0);
        wr(8'h10, 32'h2);
        check("R6 irq error unmasked", {31'b0, irq0}, 32'h1);
        rd(8'h08, a, b); check("R4 error bit sticky", a, 32'h2);
        wr(8'h08, 32'h2);
        rd(8'h08, a, b); check("R4 error bit w1c", a, 32'h0);
        check("R6 irq after w1c", {31'b0, irq0}, 32'h0);
        wr(8'h14, 32'h3);
        rd(8'h0C, a, b); check("R5 mask disable sets", a, 32'h3);
        rd(8'h14, a, b); check("R5 disable reg reads zero", a, 32'h0);
    endtask

    task automatic t_gating();
        logic [31:0] a, b;
        src_ok = 1'b0;
        pulse(1); pulse(2);
        rd(8'h04, a, b); check("R7 faults ignored modern", a, 32'h0);
        check("R7 faults ignored legacy", b, 32'h0);
        pulse(0);
        rd(8'h04, a, b); check("R7 done accepted without source", a, 32'h1);
        wr(8'h00, 32'h38);
        src_ok = 1'b1; cert_unit_en = 1'b0;
        pulse(1);
        rd(8'h04, a, b); check("R7 noise fault accepted", a, 32'h2);
        pulse(2);
        rd(8'h04, a, b);
        check("R8 modern ignores unit enable", a, 32'hA);
        check("R8 legacy drops test fault", b, 32'h2);
        cert_unit_en = 1'b1;
        pulse(2);
        rd(8'h04, a, b); check("R8 legacy takes test fault", b, 32'hA);
        wr(8'h00, 32'h38);
        rd(8'h04, a, b); check("R2 clear all flags", a | b, 32'h0);
        cert_unit_en = 1'b0;
    endtask

    task automatic t_priority();
        logic [31:0] a, b;
        @(negedge clk);
        evt_done = 1'b1; wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h8;
        @(negedge clk);
        evt_done = 1'b0; wr_en = 1'b0; wr_data = '0;
        rd(8'h04, a, b); check("R9 event beats clear", a, 32'h1);
        @(negedge clk);
        err_evt = 1'b1; wr_en = 1'b1; wr_addr = 8'h08; wr_data = 32'h2;
        @(negedge clk);
        err_evt = 1'b0; wr_en = 1'b0; wr_data = '0;
        rd(8'h08, a, b); check("R9 error beats w1c", a, 32'h2);
        wr(8'h00, 32'h38);
        wr(8'h08, 32'h2);
    endtask

    task automatic t_soft_reset();
        logic [31:0] a, b;
        wr(8'h00, 32'h7);
        pulse(0); pulse(1); pulse(3);
        rd(8'h08, a, b); check("R3 core bit with all enabled", a, 32'h3);
        @(negedge clk);
        soft_rst = 1'b1; evt_done = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; evt_done = 1'b0;
        rd(8'h04, a, b); check("R10 flags cleared", a, 32'h0);
        rd(8'h08, a, b); check("R10 core bit cleared, error kept", a, 32'h2);
        rd(8'h00, a, b); check("R10 enables kept", a, 32'h7);
        rd(8'h0C, a, b); check("R10 mask kept", a, 32'h3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_done_path();
        t_err_bit();
        t_gating();
        t_priority();
        t_soft_reset();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule